// File: doc/BRIEF.md
# Serial Audio Receive Deserializer with TDM Framing

This block sits on the receive side of a serial audio port. It watches a bit clock, a word-select line and a serial data line, all oversampled by a faster system clock. It cuts the bit stream into channel slots and assembles each slot into a parallel sample word. Finished words go to a receive FIFO through a valid/ready push port. Two framings are supported. In two-channel mode, word-select low marks the first channel and high marks the second. In TDM mode, a rising edge of word-select opens a frame of consecutive slots of equal width. In both modes the first bit of a slot is taken one bit clock after the word-select edge that opens it.

Software programs the following: slot width, number of valid bits in a slot, bit order, whether the valid bits sit at the start or the end of the slot, mono channel selection, per-slot enables in TDM, and one of three stop conditions. Reception arms on a rising edge of the start bit and only captures after the next frame edge. A one-cycle event fires when the number of words accepted by the FIFO since the last start reaches a programmed 10-bit count.

Push-port rules: `out_data`/`out_chan` are held stable while `out_valid` is high and `out_ready` is low. The serial line cannot be paused. A word that completes while the holding register is still full and not being accepted is discarded. Low `out_ready` with `out_valid` high is the FIFO-full condition.

Top module: `rx_tdm_deser`

## Requirements
- R1: In two-channel mode (`cfg_tdm`=0), a word-select transition opens a slot whose channel is the new word-select level (0 = channel 0, 1 = channel 1). Its first data bit is sampled at the next bit-clock rising edge. The slot holds `cfg_slot_bits_m1`+1 bits, and the word is emitted after its last bit.
- R2: In TDM mode (`cfg_tdm`=1), only a rising edge of word-select opens a frame. Slots 0 to `cfg_chan_cnt_m1` follow back to back, each `cfg_slot_bits_m1`+1 bits wide, and each word is tagged with its slot number on `out_chan`. Falling edges of word-select are ignored.
- R3: With `cfg_lsb_first`=1 the first valid bit received is bit 0 of the sample. With `cfg_lsb_first`=0 it is the most significant valid bit.
- R4: The sample has `cfg_valid_bits_m1`+1 bits and is right-justified in `out_data` with zeros above. With `cfg_left_align`=1 the valid bits are the first ones of the slot. With 0 they are the last ones. Other slot bits are ignored.
- R5: In TDM mode, a slot whose bit in `cfg_chan_en` is 0 still produces a word, and that word is all zero.
- R6: With `cfg_mono`=1 in two-channel mode, only one channel is pushed: channel 0 when `cfg_mono_first`=1, channel 1 when it is 0.
- R7: Stop mode 0 (`cfg_stop_mode`=0) stops reception only when `rx_start` is low. A pulse on `rx_eof` has no effect.
- R8: Stop mode 1 also stops reception when `rx_eof` pulses.
- R9: Stop mode 2 also stops reception as soon as the FIFO is full (`out_valid`=1 while `out_ready`=0).
- R10: While `out_valid`=1 and `out_ready`=0, the output word and channel stay unchanged. A word completing in that state is discarded.
- R11: `word_evt` pulses for one cycle, in the cycle after the handshake of the Nth accepted word since the last rising edge of `rx_start`, where N = `cfg_evt_words`. N=0 never fires.
- R12: After reset `out_valid` and `word_evt` are 0.
- R13: Once stopped, no words are produced until `rx_start` rises again. Capture then resumes from the next frame edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Word select / frame sync |
| sd_in | input | 1 | Serial data |
| rx_start | input | 1 | Reception enable; a rising edge arms and clears the word count |
| rx_eof | input | 1 | End-of-frame indication (stop mode 1) |
| cfg_stop_mode | input | 2 | 0: start bit only, 1: also end-of-frame, 2: also FIFO full |
| cfg_tdm | input | 1 | 1 selects TDM framing |
| cfg_chan_cnt_m1 | input | CHW (3) | TDM slot count minus one |
| cfg_chan_en | input | MAX_CH (8) | Per-slot enable in TDM mode |
| cfg_slot_bits_m1 | input | PW (5) | Slot width in bit clocks minus one |
| cfg_valid_bits_m1 | input | PW (5) | Valid sample bits minus one |
| cfg_lsb_first | input | 1 | 1: LSB received first |
| cfg_left_align | input | 1 | 1: valid bits at start of slot |
| cfg_mono | input | 1 | Mono mode in two-channel framing |
| cfg_mono_first | input | 1 | Mono keeps channel 0 (1) or channel 1 (0) |
| cfg_evt_words | input | CW (10) | Word count for the event, 0 disables |
| out_valid | output | 1 | Word available for the FIFO |
| out_ready | input | 1 | FIFO can accept (low means full) |
| out_data | output | DW (32) | Sample word, right-justified |
| out_chan | output | CHW (3) | Channel/slot number of the word |
| word_evt | output | 1 | One-cycle word-count event |

## Verification
The bench builds the block with DW=32, MAX_CH=8 and two synchronizer stages. The 32-bit width allows full-width slots, with the valid field placed at either end of a wider slot. Eight slots allow TDM frames of four and six channels with a sparse enable mask. The bench serializes known samples itself, in both bit orders and alignments, with filler ones in the unused bit positions. A scoreboard then compares every handshake against what those samples should become. Dedicated phases hold `out_ready` low to reach the drop and full-stop paths, pulse the end-of-frame input under two stop modes, and restart reception to clear and re-arm the word-count event.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;
  typedef enum logic [1:0] {
    STOP_START_ONLY = 2'd0,
    STOP_ON_EOF     = 2'd1,
    STOP_ON_FULL    = 2'd2,
    STOP_RESERVED   = 2'd3
  } stop_mode_e;

  function automatic int chan_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rx_pin_sync.sv
module rx_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bit_tick,
  output logic ws_o,
  output logic sd_o
);
  localparam int LAST = STAGES - 1;

  logic [2:0] pipe [STAGES];
  logic       sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      sck_prev <= 1'b0;
    end else begin
      pipe[0] <= {sck_in, ws_in, sd_in};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_prev <= pipe[LAST][2];
    end
  end

  // rising bit-clock edge seen in the system domain
  assign bit_tick = pipe[LAST][2] & ~sck_prev;
  assign ws_o     = pipe[LAST][1];
  assign sd_o     = pipe[LAST][0];
endmodule

// File: rtl/rx_slot_ctrl.sv
module rx_slot_ctrl #(
  parameter int PW  = 5,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_tick,
  input  logic           ws,
  input  logic           run,
  input  logic           cfg_tdm,
  input  logic [PW-1:0]  cfg_slot_bits_m1,
  input  logic [CHW-1:0] cfg_chan_cnt_m1,
  output logic           cap_en,
  output logic           cap_last,
  output logic           cap_active,
  output logic [PW-1:0]  bit_pos,
  output logic [CHW-1:0] slot_idx
);
  logic ws_prev;
  logic cap_on;
  logic frame_edge;
  logic at_end;

  assign frame_edge = cfg_tdm ? (ws & ~ws_prev) : (ws ^ ws_prev);
  assign at_end     = (bit_pos == cfg_slot_bits_m1);
  assign cap_en     = bit_tick & cap_on & run;
  assign cap_last   = cap_en & at_end;
  assign cap_active = cap_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ws_prev <= 1'b0;
    else if (bit_tick) ws_prev <= ws;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_on   <= 1'b0;
      bit_pos  <= '0;
      slot_idx <= '0;
    end else if (!run) begin
      cap_on <= 1'b0;
    end else if (bit_tick) begin
      if (cap_on) begin
        if (at_end) begin
          bit_pos <= '0;
          if (cfg_tdm && (slot_idx < cfg_chan_cnt_m1)) slot_idx <= slot_idx + 1'b1;
          else                                       cap_on   <= 1'b0;
        end else begin
          bit_pos <= bit_pos + 1'b1;
        end
      end
      // a frame edge overrides: the bit taken on this tick closed the old slot
      if (frame_edge) begin
        cap_on   <= 1'b1;
        bit_pos  <= '0;
        slot_idx <= cfg_tdm ? '0 : CHW'(ws);
      end
    end
  end

  p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_on |-> (bit_pos <= cfg_slot_bits_m1));

  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_on && cfg_tdm) |-> (slot_idx <= cfg_chan_cnt_m1));
endmodule

// File: rtl/rx_word_asm.sv
module rx_word_asm #(
  parameter int DW  = 32,
  parameter int PW  = 5,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           cap_last,
  input  logic [PW-1:0]  bit_pos,
  input  logic [CHW-1:0] slot_idx,
  input  logic           sd,
  input  logic [PW-1:0]  cfg_slot_bits_m1,
  input  logic [PW-1:0]  cfg_valid_bits_m1,
  input  logic           cfg_lsb_first,
  input  logic           cfg_left_align,
  output logic           word_stb,
  output logic [DW-1:0]  word_data,
  output logic [CHW-1:0] word_chan
);
  logic [DW-1:0] acc;
  logic [DW-1:0] acc_next;
  logic [PW-1:0] lead;
  logic [PW-1:0] rel;
  logic [PW-1:0] tgt;
  logic          in_field;

  always_comb begin
    lead     = cfg_left_align ? '0 : (cfg_slot_bits_m1 - cfg_valid_bits_m1);
    rel      = bit_pos - lead;
    in_field = (bit_pos >= lead) && (rel <= cfg_valid_bits_m1);
    tgt      = cfg_lsb_first ? rel : (cfg_valid_bits_m1 - rel);
    acc_next = (bit_pos == '0) ? '0 : acc;
    if (in_field) acc_next[tgt] = sd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      word_stb  <= 1'b0;
      word_data <= '0;
      word_chan <= '0;
    end else begin
      word_stb <= cap_last;
      if (cap_en) acc <= acc_next;
      if (cap_last) begin
        word_data <= acc_next;
        word_chan <= slot_idx;
      end
    end
  end

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> ((word_data >> ({1'b0, cfg_valid_bits_m1} + 1'b1)) == '0));
endmodule

// File: rtl/rx_word_event.sv
module rx_word_event #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          accept,
  input  logic [CW-1:0] target,
  output logic          evt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= accept && !clear && (target != '0) && (cnt != CNT_MAX) && (cnt_inc == target);
      if (clear)                          cnt <= '0;
      else if (accept && cnt != CNT_MAX)  cnt <= cnt_inc;
    end
  end

  p_evt_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/rx_tdm_deser.sv
module rx_tdm_deser
  import rx_deser_pkg::*;
#(
  parameter int DW          = 32,
  parameter int MAX_CH      = 8,
  parameter int CW          = 10,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(DW),
  localparam int CHW        = chan_bits(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  input  logic              rx_start,
  input  logic              rx_eof,
  input  logic [1:0]        cfg_stop_mode,
  input  logic              cfg_tdm,
  input  logic [CHW-1:0]    cfg_chan_cnt_m1,
  input  logic [MAX_CH-1:0] cfg_chan_en,
  input  logic [PW-1:0]     cfg_slot_bits_m1,
  input  logic [PW-1:0]     cfg_valid_bits_m1,
  input  logic              cfg_lsb_first,
  input  logic              cfg_left_align,
  input  logic              cfg_mono,
  input  logic              cfg_mono_first,
  input  logic [CW-1:0]     cfg_evt_words,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [CHW-1:0]    out_chan,
  output logic              word_evt
);
  stop_mode_e stop_mode;
  logic bit_tick, ws_s, sd_s;
  logic start_q, start_rise, running, stop_req, fifo_full;
  logic cap_en, cap_last, cap_active;
  logic [PW-1:0]  bit_pos;
  logic [CHW-1:0] slot_idx;
  logic           word_stb;
  logic [DW-1:0]  word_data;
  logic [CHW-1:0] word_chan;
  logic           keep, load;
  logic [DW-1:0]  data_f;

  assign stop_mode = stop_mode_e'(cfg_stop_mode);

  rx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .bit_tick(bit_tick), .ws_o(ws_s), .sd_o(sd_s)
  );

  // run control
  assign start_rise = rx_start & ~start_q;
  assign fifo_full  = out_valid & ~out_ready;
  assign stop_req   = ~rx_start
                    | ((stop_mode == STOP_ON_EOF)  & rx_eof)
                    | ((stop_mode == STOP_ON_FULL) & fifo_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      running <= 1'b0;
    end else begin
      start_q <= rx_start;
      if (start_rise)    running <= 1'b1;
      else if (stop_req) running <= 1'b0;
    end
  end

  rx_slot_ctrl #(.PW(PW), .CHW(CHW)) u_slot (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ws(ws_s), .run(running),
    .cfg_tdm(cfg_tdm), .cfg_slot_bits_m1(cfg_slot_bits_m1),
    .cfg_chan_cnt_m1(cfg_chan_cnt_m1),
    .cap_en(cap_en), .cap_last(cap_last), .cap_active(cap_active),
    .bit_pos(bit_pos), .slot_idx(slot_idx)
  );

  rx_word_asm #(.DW(DW), .PW(PW), .CHW(CHW)) u_asm (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_last(cap_last),
    .bit_pos(bit_pos), .slot_idx(slot_idx), .sd(sd_s),
    .cfg_slot_bits_m1(cfg_slot_bits_m1), .cfg_valid_bits_m1(cfg_valid_bits_m1),
    .cfg_lsb_first(cfg_lsb_first), .cfg_left_align(cfg_left_align),
    .word_stb(word_stb), .word_data(word_data), .word_chan(word_chan)
  );

  // channel filtering: mono selection and TDM slot masking
  always_comb begin
    keep = word_stb;
    if (cfg_mono && !cfg_tdm)
      keep = word_stb && (word_chan == (cfg_mono_first ? CHW'(0) : CHW'(1)));
    data_f = (cfg_tdm && !cfg_chan_en[word_chan]) ? '0 : word_data;
  end

  assign load = keep && (!out_valid || out_ready);

  // push-side holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= data_f;
        out_chan  <= word_chan;
      end
    end
  end

  rx_word_event #(.CW(CW)) u_evt (
    .clk(clk), .rst_n(rst_n), .clear(start_rise),
    .accept(out_valid & out_ready), .target(cfg_evt_words), .evt(word_evt)
  );

  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  p_evt_follows_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_evt |-> $past(out_valid && out_ready));

  p_full_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_mode == STOP_ON_FULL) && fifo_full && rx_start && start_q) |=> ##1 !cap_active);

  p_disabled_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_tdm && !cfg_chan_en[word_chan]) |=> (out_data == '0));

  p_idle_no_capture_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && $past(!running)) |-> !cap_active);
endmodule

// File: tb/sim_rx_tdm_deser.sv
module sim_rx_tdm_deser;
  localparam int DW = 32;
  localparam int MAX_CH = 8;
  localparam int CHW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic rx_start = 1'b0, rx_eof = 1'b0;
  logic [1:0] cfg_stop_mode = 2'd0;
  logic cfg_tdm = 1'b0;
  logic [CHW-1:0] cfg_chan_cnt_m1 = '0;
  logic [MAX_CH-1:0] cfg_chan_en = '1;
  logic [4:0] cfg_slot_bits_m1 = 5'd15, cfg_valid_bits_m1 = 5'd15;
  logic cfg_lsb_first = 1'b0, cfg_left_align = 1'b1;
  logic cfg_mono = 1'b0, cfg_mono_first = 1'b1;
  logic [9:0] cfg_evt_words = '0;
  logic out_valid, out_ready = 1'b1, word_evt;
  logic [DW-1:0] out_data;
  logic [CHW-1:0] out_chan;

  always #2.5 clk = ~clk;

  rx_tdm_deser #(.DW(DW), .MAX_CH(MAX_CH), .CW(10), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .ws_in(ws), .sd_in(sd),
    .rx_start(rx_start), .rx_eof(rx_eof), .cfg_stop_mode(cfg_stop_mode),
    .cfg_tdm(cfg_tdm), .cfg_chan_cnt_m1(cfg_chan_cnt_m1), .cfg_chan_en(cfg_chan_en),
    .cfg_slot_bits_m1(cfg_slot_bits_m1), .cfg_valid_bits_m1(cfg_valid_bits_m1),
    .cfg_lsb_first(cfg_lsb_first), .cfg_left_align(cfg_left_align),
    .cfg_mono(cfg_mono), .cfg_mono_first(cfg_mono_first), .cfg_evt_words(cfg_evt_words),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .word_evt(word_evt)
  );

  int n_chk = 0, n_bad = 0;
  int acc_cnt = 0, evt_cnt = 0;
  string cur_req = "R1";
  logic [CHW+DW-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each handshake with the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      acc_cnt++;
      if (exp_q.size() == 0) check(1'b0, {cur_req, " unexpected word"}, {out_chan, out_data}, 0);
      else begin
        logic [CHW+DW-1:0] e;
        e = exp_q.pop_front();
        check({out_chan, out_data} == e, cur_req, {out_chan, out_data}, e);
      end
    end
    if (rst_n && word_evt) begin
      evt_cnt++;
      check(acc_cnt == int'(cfg_evt_words), "R11 event position", acc_cnt, cfg_evt_words);
    end
  end

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk); ws = w; sd = d;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  function automatic logic [31:0] serialize(input logic [31:0] val, input int s, input int v,
                                            input bit lsb, input bit left);
    logic [31:0] b;
    int lead;
    lead = left ? 0 : s - v;
    b = '1;
    for (int i = 0; i < s; i++) begin
      int k;
      k = i - lead;
      if (k >= 0 && k < v) b[i] = lsb ? val[k] : val[v-1-k];
    end
    return b;
  endfunction

  function automatic logic [31:0] rand_sample(input int v);
    logic [63:0] m;
    m = (64'd1 << v) - 64'd1;
    return $urandom() & m[31:0];
  endfunction

  // two-channel frames; exp_max limits how many words are expected
  task automatic stereo_frames(input int nfr, input bit exp_on, input int exp_max);
    int s, v, pushed;
    s = int'(cfg_slot_bits_m1) + 1;
    v = int'(cfg_valid_bits_m1) + 1;
    pushed = 0;
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int fr = 0; fr < nfr; fr++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [31:0] val, st;
        bit kept;
        val = rand_sample(v);
        st = serialize(val, s, v, cfg_lsb_first, cfg_left_align);
        kept = !cfg_mono || (ch == (cfg_mono_first ? 0 : 1));
        if (exp_on && kept && pushed < exp_max) begin
          exp_q.push_back({CHW'(ch), val});
          pushed++;
        end
        for (int i = 0; i < s; i++)
          send_bit((i == s - 1) ? logic'(ch == 0) : logic'(ch == 1), st[i]);
      end
    end
    repeat (24) @(negedge clk);
  endtask

  task automatic tdm_frames(input int nfr, input bit exp_on);
    int s, v, n;
    s = int'(cfg_slot_bits_m1) + 1;
    v = int'(cfg_valid_bits_m1) + 1;
    n = int'(cfg_chan_cnt_m1) + 1;
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    for (int fr = 0; fr < nfr; fr++) begin
      for (int ch = 0; ch < n; ch++) begin
        logic [31:0] val, st;
        val = rand_sample(v);
        st = serialize(val, s, v, cfg_lsb_first, cfg_left_align);
        if (exp_on) exp_q.push_back({CHW'(ch), cfg_chan_en[ch] ? val : 32'd0});
        for (int i = 0; i < s; i++)
          send_bit(logic'(ch == n - 1 && i == s - 1), st[i]);
      end
    end
    repeat (24) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); rx_start = 1'b0;
    repeat (3) @(negedge clk);
    rx_start = 1'b1; acc_cnt = 0;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, {req, " all expected words delivered"}, exp_q.size(), 0);
  endtask

  task automatic fmt(input bit tdm, input int s, input int v, input bit lsb, input bit left, input int nch);
    @(negedge clk); rx_start = 1'b0;
    cfg_tdm = tdm; cfg_slot_bits_m1 = 5'(s - 1); cfg_valid_bits_m1 = 5'(v - 1);
    cfg_lsb_first = lsb; cfg_left_align = left; cfg_chan_cnt_m1 = CHW'(nch - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
    check(word_evt == 1'b0, "R12 word_evt after reset", word_evt, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: two-channel, full 16-bit slots, MSB first
    cur_req = "R1"; fmt(0, 16, 16, 0, 1, 2); restart(); stereo_frames(3, 1, 100); drain("R1");
    // R3 R4: right alignment in wider slot, MSB first
    cur_req = "R4"; fmt(0, 24, 16, 0, 0, 2); restart(); stereo_frames(2, 1, 100); drain("R4");
    // R3 R4: LSB first, left aligned, 20 of 32 bits
    cur_req = "R3"; fmt(0, 32, 20, 1, 1, 2); restart(); stereo_frames(2, 1, 100); drain("R3");
    cur_req = "R3"; fmt(0, 12, 12, 1, 0, 2); restart(); stereo_frames(2, 1, 100); drain("R3");
    // R2 R5: TDM four slots with a mask
    cur_req = "R5"; fmt(1, 8, 8, 0, 1, 4); cfg_chan_en = 8'b0000_1011;
    restart(); tdm_frames(2, 1); drain("R5");
    cur_req = "R2"; fmt(1, 16, 12, 1, 0, 6); cfg_chan_en = 8'b0011_0110;
    restart(); tdm_frames(2, 1); drain("R2");
    cfg_chan_en = '1;
    // R6: mono selection
    cur_req = "R6"; fmt(0, 16, 16, 0, 1, 2); cfg_mono = 1'b1; cfg_mono_first = 1'b1;
    restart(); stereo_frames(3, 1, 100); drain("R6");
    cur_req = "R6"; fmt(0, 16, 16, 0, 1, 2); cfg_mono_first = 1'b0;
    restart(); stereo_frames(3, 1, 100); drain("R6");
    cfg_mono = 1'b0;
    // R7: end-of-frame ignored in mode 0
    cur_req = "R7"; fmt(0, 16, 16, 0, 1, 2); cfg_stop_mode = 2'd0;
    restart(); stereo_frames(1, 1, 100);
    @(negedge clk); rx_eof = 1'b1; @(negedge clk); rx_eof = 1'b0;
    stereo_frames(1, 1, 100); drain("R7");
    // R13: start cleared stops, rising start resumes
    cur_req = "R13"; @(negedge clk); rx_start = 1'b0;
    stereo_frames(2, 0, 0); drain("R13");
    restart(); stereo_frames(1, 1, 100); drain("R13");
    // R8: end-of-frame stops in mode 1
    cur_req = "R8"; fmt(0, 16, 16, 0, 1, 2); cfg_stop_mode = 2'd1;
    restart(); stereo_frames(1, 1, 100);
    @(negedge clk); rx_eof = 1'b1; @(negedge clk); rx_eof = 1'b0;
    stereo_frames(2, 0, 0); drain("R8");
    // R10: back-pressure in mode 0, second word of the frame dropped
    cur_req = "R10"; fmt(0, 16, 16, 0, 1, 2); cfg_stop_mode = 2'd0;
    restart(); out_ready = 1'b0; stereo_frames(1, 1, 1);
    check(out_valid == 1'b1, "R10 word held while full", out_valid, 1);
    check(out_data == exp_q[0][DW-1:0], "R10 held data", out_data, exp_q[0][DW-1:0]);
    @(negedge clk); out_ready = 1'b1; drain("R10");
    stereo_frames(1, 1, 100); drain("R10");
    // R9: full stops reception in mode 2
    cur_req = "R9"; fmt(0, 16, 16, 0, 1, 2); cfg_stop_mode = 2'd2;
    restart(); out_ready = 1'b0; stereo_frames(1, 1, 1);
    check(out_valid == 1'b1, "R9 first word held", out_valid, 1);
    @(negedge clk); out_ready = 1'b1; drain("R9");
    stereo_frames(2, 0, 0); drain("R9");
    cfg_stop_mode = 2'd0;
    // R11: word-count event
    cur_req = "R11"; fmt(0, 16, 16, 0, 1, 2); cfg_evt_words = 10'd3; evt_cnt = 0;
    restart(); stereo_frames(3, 1, 100); drain("R11");
    check(evt_cnt == 1, "R11 single pulse", evt_cnt, 1);
    restart(); stereo_frames(2, 1, 100); drain("R11");
    check(evt_cnt == 2, "R11 count cleared by start", evt_cnt, 2);
    fmt(0, 16, 16, 0, 1, 2); cfg_evt_words = 10'd0;
    restart(); stereo_frames(2, 1, 100); drain("R11");
    check(evt_cnt == 2, "R11 zero target disables", evt_cnt, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule